// File: doc/BRIEF.md
# Recursive Cascaded CORDIC Rotator

This block rotates a two-dimensional vector by a given angle using shift-and-add micro-rotations. The N micro-rotations are split evenly over K identical hardware units connected in a chain. Each unit runs its own share of G = N/K micro-rotations one after another, one per clock, and feeds its adder results back into itself. When its share is done, it passes the partial vector and the residual angle to the next unit in the chain. All units share one G-cycle phase. Unit 0 therefore takes a new sample every G cycles, and a finished result leaves the last unit every G cycles.

Each unit handles a fixed range of shift amounts, starting at m = k·G. The upper L−m bits of each word are wired to a small shifter that covers only G positions, and the result is sign-extended back to L bits. Angles are signed binary fractions of a half turn: the value 2^(L−1) stands for π. Valid inputs lie within ±π/2. The output carries the unit CORDIC gain (about 1.6468) and is not corrected for it.

Top module: `cordic_recursive_cascade`

## Requirements
- R1: While reset is high at a clock edge, the following cycle shows `in_ready` = 1 and `out_valid` = 0. No sample is in flight after reset.
- R2: `in_ready` is high on exactly one cycle in every G = N/K cycles. It is high on the first cycle after reset is released and on every G-th cycle after that.
- R3: A sample is taken only on a cycle where `in_valid` and `in_ready` are both high. `in_valid` on any other cycle produces no output.
- R4: Micro-rotation i (0 ≤ i < N) works as follows. If the residual angle z has sign bit 0, it computes x−(y>>>i), y+(x>>>i) and z−A(i). Otherwise it computes x+(y>>>i), y−(x>>>i) and z+A(i). Here >>> is an arithmetic shift, A(i) = round(atan(2^−i)·2^(L−1)/π), and all sums wrap modulo 2^L. `out_x` and `out_y` are bit-exact with N such steps.
- R5: `out_valid` is a single-cycle pulse. It appears exactly N cycles after the cycle in which the matching sample was taken, and only on cycles where `in_ready` is high.
- R6: `out_angle` is the residual angle left after all N micro-rotations, following the rule of R4.
- R7: Samples may be offered on every `in_ready` cycle, back to back. Results come out in input order, with none lost or duplicated.
- R8: Negative operands are shifted with their sign bits kept, through the pre-shifted narrow shifter at every stage. The results match the full-width arithmetic shift of R4.
- R9: For inputs with |x|,|y| ≤ 12000 and |angle| ≤ π/2, the outputs are within 24 LSB of 1.6468·(x·cosθ − y·sinθ) and 1.6468·(x·sinθ + y·cosθ).
- R10: Reset while samples are in flight discards them. None of them produces `out_valid` after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Offered sample is valid |
| in_ready | output | 1 | Unit 0 loads on this cycle |
| in_x | input | L | Vector x, two's complement |
| in_y | input | L | Vector y, two's complement |
| in_angle | input | L | Rotation angle, 2^(L−1) = π |
| out_valid | output | 1 | Result pulse |
| out_x | output | L | Rotated x, scaled by the CORDIC gain |
| out_y | output | L | Rotated y, scaled by the CORDIC gain |
| out_angle | output | L | Residual angle |

## Verification
On the phase-zero cycle, three things happen in the same clock. Unit 0 takes a fresh sample, every inner unit takes its neighbour's partial result, and the last unit presents a finished result. A back-to-back stream forces all of these onto the same edges. Each output is judged against a bit-exact reference in a queue: its position in the queue, its value, and the cycle distance from its acceptance. A collision at the handoff would show up as corrupted data or wrong ordering. Separately, `in_valid` is held high across non-ready cycles, and a reset is applied mid-stream. In both cases no stray result may emerge.

// File: rtl/cordic_rc_pkg.sv
package cordic_rc_pkg;

    typedef enum logic {
        ROT_CCW = 1'b0,
        ROT_CW  = 1'b1
    } rot_dir_e;

    // Elementary angle atan(2^-idx) expressed with 2^(aw-1) == pi, rounded.
    function automatic int atan_code(input int idx, input int aw);
        real t;
        real term;
        real acc;
        real scale;
        acc = 0.0;
        if (idx == 0) begin
            acc = 0.78539816339744830962;
        end else begin
            t = 1.0;
            for (int n = 0; n < idx; n++) t = t / 2.0;
            term = t;
            for (int n = 0; n < 16; n++) begin
                if (n % 2 == 0) acc = acc + term / (2.0 * n + 1.0);
                else            acc = acc - term / (2.0 * n + 1.0);
                term = term * t * t;
            end
        end
        scale = 1.0;
        for (int n = 1; n < aw; n++) scale = scale * 2.0;
        return $rtoi(acc * scale / 3.14159265358979323846 + 0.5);
    endfunction

endpackage

// File: rtl/cordic_rc_preshift.sv
module cordic_rc_preshift #(
    parameter int L     = 16,
    parameter int BASE  = 0,
    parameter int AMT_W = 2
) (
    input  logic signed [L-1:0]     word_i,
    input  logic        [AMT_W-1:0] amt_i,
    output logic signed [L-1:0]     word_o
);
    localparam int W = L - BASE;

    logic signed [W-1:0] hi;
    logic signed [W-1:0] sh;

    // Hardwired part of the shift: the low BASE bits never reach the shifter.
    assign hi     = word_i[L-1:BASE];
    assign sh     = hi >>> amt_i;
    assign word_o = L'(sh);
endmodule

// File: rtl/cordic_rc_unit.sv
module cordic_rc_unit
    import cordic_rc_pkg::*;
#(
    parameter int L     = 16,
    parameter int G     = 4,
    parameter int STAGE = 0,
    parameter int CW    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [CW-1:0]       step_i,
    input  logic                vld_i,
    input  logic signed [L-1:0] x_i,
    input  logic signed [L-1:0] y_i,
    input  logic signed [L-1:0] z_i,
    output logic                vld_o,
    output logic signed [L-1:0] x_o,
    output logic signed [L-1:0] y_o,
    output logic signed [L-1:0] z_o
);
    localparam int BASE = STAGE * G;

    typedef struct packed {
        logic                vld;
        logic signed [L-1:0] x;
        logic signed [L-1:0] y;
        logic signed [L-1:0] z;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic signed [L-1:0] op_x, op_y, op_z;
    logic signed [L-1:0] sh_x, sh_y;
    logic signed [L-1:0] atan_rom [G];
    rot_dir_e            dir;

    for (genvar j = 0; j < G; j++) begin : g_rom
        assign atan_rom[j] = L'(atan_code(BASE + j, L));
    end

    // Operand select: fresh pair on the load cycle, own result otherwise.
    assign op_x = load_i ? x_i : st_q.x;
    assign op_y = load_i ? y_i : st_q.y;
    assign op_z = load_i ? z_i : st_q.z;

    cordic_rc_preshift #(.L(L), .BASE(BASE), .AMT_W(CW)) u_shx (
        .word_i (op_x),
        .amt_i  (step_i),
        .word_o (sh_x)
    );

    cordic_rc_preshift #(.L(L), .BASE(BASE), .AMT_W(CW)) u_shy (
        .word_i (op_y),
        .amt_i  (step_i),
        .word_o (sh_y)
    );

    always_comb begin
        st_d = st_q;
        dir  = op_z[L-1] ? ROT_CW : ROT_CCW;
        if (load_i) st_d.vld = vld_i;
        if (dir == ROT_CCW) begin
            st_d.x = op_x - sh_y;
            st_d.y = op_y + sh_x;
            st_d.z = op_z - atan_rom[step_i];
        end else begin
            st_d.x = op_x + sh_y;
            st_d.y = op_y - sh_x;
            st_d.z = op_z + atan_rom[step_i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign x_o   = st_q.x;
    assign y_o   = st_q.y;
    assign z_o   = st_q.z;
endmodule

// File: rtl/cordic_recursive_cascade.sv
module cordic_recursive_cascade #(
    parameter int L = 16,
    parameter int N = 16,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [L-1:0] in_x,
    input  logic [L-1:0] in_y,
    input  logic [L-1:0] in_angle,
    output logic         out_valid,
    output logic [L-1:0] out_x,
    output logic [L-1:0] out_y,
    output logic [L-1:0] out_angle
);
    localparam int G  = N / K;
    localparam int CW = (G > 1) ? $clog2(G) : 1;

    typedef struct packed {
        logic [CW-1:0] phase;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;
    logic    load;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.phase == CW'(G - 1)) ctl_d.phase = '0;
        else                           ctl_d.phase = ctl_q.phase + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign load = (ctl_q.phase == '0);

    logic        [K:0]   chain_v;
    logic signed [L-1:0] chain_x [K+1];
    logic signed [L-1:0] chain_y [K+1];
    logic signed [L-1:0] chain_z [K+1];

    assign chain_v[0] = in_valid;
    assign chain_x[0] = in_x;
    assign chain_y[0] = in_y;
    assign chain_z[0] = in_angle;

    for (genvar k = 0; k < K; k++) begin : g_unit
        cordic_rc_unit #(.L(L), .G(G), .STAGE(k), .CW(CW)) u_unit (
            .clk    (clk),
            .rst    (rst),
            .load_i (load),
            .step_i (ctl_q.phase),
            .vld_i  (chain_v[k]),
            .x_i    (chain_x[k]),
            .y_i    (chain_y[k]),
            .z_i    (chain_z[k]),
            .vld_o  (chain_v[k+1]),
            .x_o    (chain_x[k+1]),
            .y_o    (chain_y[k+1]),
            .z_o    (chain_z[k+1])
        );
    end

    assign in_ready  = load;
    assign out_valid = load & chain_v[K];
    assign out_x     = chain_x[K];
    assign out_y     = chain_y[K];
    assign out_angle = chain_z[K];
endmodule

// File: rtl/cordic_rc_checker.sv
module cordic_rc_checker #(
    parameter int N = 16,
    parameter int K = 4
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid
);
    logic [7:0] pend_q;
    logic [7:0] pend_d;

    always_comb begin
        pend_d = pend_q;
        if (in_valid && in_ready) pend_d = pend_d + 8'd1;
        if (out_valid)            pend_d = pend_d - 8'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    // R2: loading is a single-cycle event (G >= 2 in every supported configuration)
    assert_ready_single_R2: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    assert_out_phase_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    assert_out_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pend_q != 8'd0));
endmodule

bind cordic_recursive_cascade cordic_rc_checker #(.N(N), .K(K)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid)
);

// File: tb/tb_cordic_recursive_cascade.sv
module tb_cordic_recursive_cascade;
    localparam int L = 16;
    localparam int N = 16;
    localparam int K = 4;
    localparam int G = N / K;
    localparam real PI = 3.14159265358979323846;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [L-1:0] in_x = '0;
    logic [L-1:0] in_y = '0;
    logic [L-1:0] in_angle = '0;
    logic         out_valid;
    logic [L-1:0] out_x, out_y, out_angle;

    cordic_recursive_cascade #(.L(L), .N(N), .K(K)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_x      (in_x),
        .in_y      (in_y),
        .in_angle  (in_angle),
        .out_valid (out_valid),
        .out_x     (out_x),
        .out_y     (out_y),
        .out_angle (out_angle)
    );

    always #5 clk = ~clk;

    typedef struct {
        int  x;
        int  y;
        int  z;
        int  cyc;
        real rx;
        real ry;
    } item_t;

    item_t sb[$];
    int    atab [N];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    out_seen = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Reference: N plain micro-rotations with full-width arithmetic shifts.
    task automatic ref_rotate(input int xi, input int yi, input int ai,
                              output int xo, output int yo, output int ao);
        logic signed [L-1:0] x, y, z, sx, sy;
        x = L'(xi); y = L'(yi); z = L'(ai);
        for (int i = 0; i < N; i++) begin
            sx = x >>> i;
            sy = y >>> i;
            if (z[L-1] == 1'b0) begin
                x = x - sy; y = y + sx; z = z - L'(atab[i]);
            end else begin
                x = x + sy; y = y - sx; z = z + L'(atab[i]);
            end
        end
        xo = int'(x); yo = int'(y); ao = int'(z);
    endtask

    task automatic send(input int xi, input int yi, input int ai);
        item_t it;
        real   gain, th;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        in_valid = 1'b1;
        in_x = L'(xi); in_y = L'(yi); in_angle = L'(ai);
        ref_rotate(xi, yi, ai, it.x, it.y, it.z);
        gain = 1.0;
        for (int i = 0; i < N; i++) gain = gain * $sqrt(1.0 + 1.0 / (4.0 ** i));
        th = ai * PI / 32768.0;
        it.rx  = gain * (xi * $cos(th) - yi * $sin(th));
        it.ry  = gain * (xi * $sin(th) + yi * $cos(th));
        it.cyc = cyc;
        sb.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every result.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            item_t it;
            out_seen++;
            if (sb.size() == 0) begin
                check(1'b0, "R3/R10", "result with no pending sample", 1, 0);
            end else begin
                it = sb.pop_front();
                check($signed(out_x) == it.x, "R4/R8", "out_x", $signed(out_x), it.x);
                check($signed(out_y) == it.y, "R4/R8", "out_y", $signed(out_y), it.y);
                check($signed(out_angle) == it.z, "R6", "out_angle", $signed(out_angle), it.z);
                check(cyc - it.cyc == N, "R5", "latency", cyc - it.cyc, N);
                check(($signed(out_x) - it.rx) <= 24.0 && (it.rx - $signed(out_x)) <= 24.0 &&
                      ($signed(out_y) - it.ry) <= 24.0 && (it.ry - $signed(out_y)) <= 24.0,
                      "R9", "rotation accuracy x", $signed(out_x), $rtoi(it.rx));
            end
        end
    end

    initial begin
        #(200000 * 10);
        check(1'b0, "watchdog", "timeout", cyc, 0);
        finish_run();
    end

    task automatic drain();
        repeat (N + 2 * G) @(negedge clk);
    endtask

    initial begin
        int seen0;
        for (int i = 0; i < N; i++)
            atab[i] = $rtoi($atan(1.0 / (2.0 ** i)) * 32768.0 / PI + 0.5);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R2: ready cadence
        for (int c = 0; c < 3 * G; c++) begin
            check(in_ready == (c % G == 0), "R2", "in_ready cadence", in_ready, c % G == 0);
            @(negedge clk);
        end

        // R4/R6/R9: directed corners
        send(10000, 0, 0);
        send(10000, 0, 16384);
        send(10000, 0, -16384);
        send(0, 12000, 8192);
        send(-12000, -12000, -5000);   // R8: negative operands
        send(-7, 3, 100);              // R8: small negative values where truncation shows
        drain();

        // R7: back-to-back stream of mixed patterns
        for (int i = 0; i < 40; i++)
            send($urandom_range(24000) - 12000, $urandom_range(24000) - 12000,
                 $urandom_range(32768) - 16384);
        drain();

        // Spaced samples
        for (int i = 0; i < 5; i++) begin
            send($urandom_range(24000) - 12000, $urandom_range(24000) - 12000,
                 $urandom_range(32768) - 16384);
            repeat (i * 3 + 1) @(negedge clk);
        end
        drain();

        // R3: in_valid high only on non-ready cycles must be ignored
        seen0 = out_seen;
        for (int c = 0; c < 4 * G; c++) begin
            @(negedge clk);
            in_valid = !in_ready;
            in_x = L'($urandom); in_y = L'($urandom); in_angle = L'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0;
        drain();
        check(out_seen == seen0, "R3", "outputs after off-phase valid", out_seen - seen0, 0);

        // R10: reset mid-stream discards in-flight samples
        send(5000, 1000, 3000);
        send(-4000, 2000, -9000);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        sb.delete();
        seen0 = out_seen;
        rst = 1'b0;
        check(in_ready == 1'b1 && out_valid == 1'b0, "R10", "state after mid-stream reset",
              {in_ready, out_valid}, 2);
        repeat (2 * N) @(negedge clk);
        check(out_seen == seen0, "R10", "stale outputs after reset", out_seen - seen0, 0);

        // Fresh traffic after reset still correct
        send(9000, -3000, 12000);
        send(-9000, 3000, -12000);
        drain();

        check(sb.size() == 0, "R7", "results left pending", sb.size(), 0);
        finish_run();
    end
endmodule